// File: doc/BRIEF.md
# Real-Time-Clock Operation Sequencer

This block sits above a byte-wide serial master that talks to a battery-backed clock chip. A client asks for one whole operation (read the time, set the time, read one parameter-RAM byte or write one) and the block breaks it into single-register transactions. It hands each one to the master with a start/done handshake and reports a 32-bit result with an error flag when the operation ends. The chip counts seconds from an epoch 2082844800 seconds earlier than the Unix epoch, and the block adds or removes that gap on the way in and out.

Reading the time takes a full four-byte pass and repeats it until two passes in a row agree, because the counter may tick between byte reads. Each write operation is wrapped in a pair of writes to the chip's write-guard register: the first opens the chip for writing, and the last closes it again.

The controller is one state machine with five states. `S_IDLE` waits for a request and goes to `S_LAUNCH` when one is taken. `S_LAUNCH` pulses the transaction start and always goes to `S_AWAIT`. `S_AWAIT` waits for the transaction's done. After a step that is not the last, it returns to `S_LAUNCH`. After the last step of a time-read pass it goes to `S_JUDGE`. After the last step of any other operation it goes to `S_REPORT`. `S_JUDGE` compares the new pass with the previous one. On a match or an exhausted retry budget it goes to `S_REPORT`, and otherwise it starts a new pass in `S_LAUNCH`. `S_REPORT` pulses done and returns to `S_IDLE`.

Top module: `rtc_op_sequencer`

## Requirements
- R1: `req_op` selects the operation: 0 reads the time, 1 sets the time, 2 reads a RAM byte, 3 writes a RAM byte. A time-read pass reads registers 0, 1, 2 and 3 in that order. It forms a 32-bit value in which register 3 is the most significant byte and register 0 the least.
- R2: Passes repeat until one pass equals the pass before it. The result is that value minus 2082844800, taken modulo 2^32.
- R3: If eleven passes give no two equal in a row, the result is 0 and `error` is 1. Every operation that completes otherwise reports `error` 0.
- R4: A time set performs these writes in order: 0x55 to register 13, then the four bytes of `req_time` + 2082844800 (mod 2^32) to registers 0, 1, 2 and 3 (least significant byte first), then 0xD5 to register 13. Its result is 0.
- R5: A RAM write performs three writes in order: 0x55 to register 13, an extended write of `req_wdata` at `req_addr`, then 0xD5 to register 13. Its result is 0.
- R6: A RAM read is one extended read at `req_addr` with no access to register 13. The result is the returned byte, zero-extended.
- R7: A request is taken only while `busy` is 0. A request made while busy starts no transaction and does not change the result of the operation in progress.
- R8: `done` is high for exactly one cycle per operation and `busy` falls in the next cycle. `result` and `error` hold their values until the next operation completes.
- R9: `xact_start` is high for one cycle at a time. No new start comes before the master has answered the previous one with `xact_done`.
- R10: A transaction carries `xact_write` (1 for a write) and `xact_reg`. It also carries `xact_ext`, which is 1 only for parameter-RAM access; such an access uses register code 14 and carries its address on `xact_addr`. `xact_wdata` holds the byte of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 2 | Operation code |
| req_time | input | 32 | Unix-epoch time for a time set |
| req_addr | input | 8 | Parameter-RAM byte address |
| req_wdata | input | 8 | Parameter-RAM byte to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Time, RAM byte, or 0 |
| error | output | 1 | Time read found no stable value |
| xact_start | output | 1 | Start one transaction |
| xact_write | output | 1 | Transaction is a write |
| xact_ext | output | 1 | Transaction is a parameter-RAM access |
| xact_reg | output | 4 | Register code |
| xact_addr | output | 8 | Parameter-RAM address |
| xact_wdata | output | 8 | Byte to write |
| xact_done | input | 1 | Transaction finished |
| xact_rdata | input | 8 | Byte returned by a read |

## Verification
Time reads run against a modelled clock that advances by one after a chosen number of passes: zero, three, nine and ten. The first case settles after two passes and the middle two settle later. The last two sit on either side of the eleven-pass limit, so they separate an off-by-one retry budget from a correct one. Start times below and above the epoch gap, and a set time near 2^32, show whether the offset arithmetic wraps. Transaction latencies vary from one to three cycles, so a design that assumes a fixed answer time goes wrong. A RAM write followed by reads of the same and of a different address shows whether the guard writes, the address and the data reach the chip. A request injected during a long time read shows whether stray requests are ignored.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

    typedef enum logic [1:0] {
        OP_GET_TIME  = 2'd0,
        OP_SET_TIME  = 2'd1,
        OP_RAM_READ  = 2'd2,
        OP_RAM_WRITE = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LAUNCH,
        S_AWAIT,
        S_JUDGE,
        S_REPORT
    } state_e;

    localparam int RAM_AW  = 8;
    localparam int BYTE_W  = 8;
    localparam int REG_W   = 4;

    typedef struct packed {
        logic              write;
        logic              ext;
        logic [REG_W-1:0]  reg_sel;
        logic [RAM_AW-1:0] ram_addr;
        logic [BYTE_W-1:0] wdata;
    } txn_t;

    localparam logic [31:0]       EPOCH_GAP  = 32'd2082844800;
    localparam logic [REG_W-1:0]  REG_GUARD  = 4'd13;
    localparam logic [REG_W-1:0]  REG_EXT    = 4'd14;
    localparam logic [BYTE_W-1:0] GUARD_OPEN = 8'h55;
    localparam logic [BYTE_W-1:0] GUARD_SHUT = 8'hD5;

endpackage

// File: rtl/rtc_epoch_conv.sv
module rtc_epoch_conv
    import rtc_seq_pkg::*;
#(
    parameter int TIME_W = 32
) (
    input  logic [TIME_W-1:0] chip_in,
    input  logic [TIME_W-1:0] unix_in,
    output logic [TIME_W-1:0] unix_out,
    output logic [TIME_W-1:0] chip_out
);
    localparam logic [TIME_W-1:0] GAP = TIME_W'(EPOCH_GAP);

    // Both directions wrap modulo 2^TIME_W.
    assign unix_out = chip_in - GAP;
    assign chip_out = unix_in + GAP;
endmodule

// File: rtl/rtc_pass_buffer.sv
module rtc_pass_buffer #(
    parameter int W  = 32,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [$clog2(W/BW)-1:0] lane,
    input  logic [BW-1:0] byte_in,
    input  logic          roll,
    output logic [W-1:0]  cur,
    output logic [W-1:0]  prev,
    output logic          match
);
    localparam int LANES = W / BW;
    localparam int LW    = $clog2(LANES);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cur[g*BW +: BW] <= '0;
            end else if (capture && lane == LW'(g)) begin
                cur[g*BW +: BW] <= byte_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '0;
        end else if (roll) begin
            prev <= cur;
        end
    end

    assign match = (cur == prev);
endmodule

// File: rtl/rtc_step_plan.sv
module rtc_step_plan
    import rtc_seq_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int STEP_W = 3
) (
    input  op_e                op,
    input  logic [STEP_W-1:0]  step,
    input  logic [TIME_W-1:0]  chip_time,
    input  logic [RAM_AW-1:0]  ram_addr,
    input  logic [BYTE_W-1:0]  ram_data,
    output txn_t               txn,
    output logic               last
);
    localparam int LANES = TIME_W / BYTE_W;
    localparam int LW    = $clog2(LANES);
    localparam logic [STEP_W-1:0] SET_LAST = STEP_W'(LANES + 1);

    logic [LW-1:0] get_lane;
    logic [LW-1:0] set_lane;

    always_comb begin
        get_lane = LW'(step);
        set_lane = LW'(step - STEP_W'(1));
        txn      = '0;
        last     = 1'b0;
        unique case (op)
            OP_GET_TIME: begin
                txn.reg_sel = REG_W'(get_lane);
                last        = (step == STEP_W'(LANES - 1));
            end
            OP_SET_TIME: begin
                txn.write = 1'b1;
                if (step == '0) begin
                    txn.reg_sel = REG_GUARD;
                    txn.wdata   = GUARD_OPEN;
                end else if (step == SET_LAST) begin
                    txn.reg_sel = REG_GUARD;
                    txn.wdata   = GUARD_SHUT;
                    last        = 1'b1;
                end else begin
                    txn.reg_sel = REG_W'(set_lane);
                    txn.wdata   = chip_time[int'(set_lane)*BYTE_W +: BYTE_W];
                end
            end
            OP_RAM_READ: begin
                txn.ext      = 1'b1;
                txn.reg_sel  = REG_EXT;
                txn.ram_addr = ram_addr;
                last         = 1'b1;
            end
            OP_RAM_WRITE: begin
                txn.write = 1'b1;
                if (step == '0) begin
                    txn.reg_sel = REG_GUARD;
                    txn.wdata   = GUARD_OPEN;
                end else if (step == STEP_W'(1)) begin
                    txn.ext      = 1'b1;
                    txn.reg_sel  = REG_EXT;
                    txn.ram_addr = ram_addr;
                    txn.wdata    = ram_data;
                end else begin
                    txn.reg_sel = REG_GUARD;
                    txn.wdata   = GUARD_SHUT;
                    last        = 1'b1;
                end
            end
            default: last = 1'b1;
        endcase
    end
endmodule

// File: rtl/rtc_op_sequencer.sv
module rtc_op_sequencer
    import rtc_seq_pkg::*;
#(
    parameter int TIME_W      = 32,
    parameter int MAX_RETRIES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [TIME_W-1:0] req_time,
    input  logic [7:0]        req_addr,
    input  logic [7:0]        req_wdata,
    output logic              busy,
    output logic              done,
    output logic [TIME_W-1:0] result,
    output logic              error,
    output logic              xact_start,
    output logic              xact_write,
    output logic              xact_ext,
    output logic [3:0]        xact_reg,
    output logic [7:0]        xact_addr,
    output logic [7:0]        xact_wdata,
    input  logic              xact_done,
    input  logic [7:0]        xact_rdata
);
    localparam int LANES  = TIME_W / BYTE_W;
    localparam int LW     = $clog2(LANES);
    localparam int STEP_W = $clog2(LANES + 2);
    localparam int PASS_W = $clog2(MAX_RETRIES + 1);

    state_e              state_q, state_d;
    op_e                 op_q;
    logic [TIME_W-1:0]   time_q;
    logic [RAM_AW-1:0]   addr_q;
    logic [BYTE_W-1:0]   data_q;
    logic [STEP_W-1:0]   step_q;
    logic [PASS_W-1:0]   passes_q;

    txn_t                txn;
    logic                step_last;
    logic [TIME_W-1:0]   chip_set, unix_get;
    logic [TIME_W-1:0]   pass_cur, pass_prev;
    logic                pass_match;
    logic                capture, roll;
    logic                judge_ok, judge_fail;

    rtc_epoch_conv #(.TIME_W(TIME_W)) i_conv (
        .chip_in  (pass_cur),
        .unix_in  (time_q),
        .unix_out (unix_get),
        .chip_out (chip_set)
    );

    rtc_step_plan #(.TIME_W(TIME_W), .STEP_W(STEP_W)) i_plan (
        .op        (op_q),
        .step      (step_q),
        .chip_time (chip_set),
        .ram_addr  (addr_q),
        .ram_data  (data_q),
        .txn       (txn),
        .last      (step_last)
    );

    rtc_pass_buffer #(.W(TIME_W), .BW(BYTE_W)) i_pass (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .lane    (LW'(step_q)),
        .byte_in (xact_rdata),
        .roll    (roll),
        .cur     (pass_cur),
        .prev    (pass_prev),
        .match   (pass_match)
    );

    assign judge_ok   = (passes_q != '0) && pass_match;
    assign judge_fail = !judge_ok && (passes_q == PASS_W'(MAX_RETRIES));
    assign capture    = (state_q == S_AWAIT) && xact_done && (op_q == OP_GET_TIME);
    assign roll       = (state_q == S_JUDGE) && !judge_ok && !judge_fail;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_d = S_LAUNCH;
            S_LAUNCH: state_d = S_AWAIT;
            S_AWAIT: begin
                if (xact_done) begin
                    if (!step_last)                state_d = S_LAUNCH;
                    else if (op_q == OP_GET_TIME)  state_d = S_JUDGE;
                    else                           state_d = S_REPORT;
                end
            end
            S_JUDGE:  state_d = (judge_ok || judge_fail) ? S_REPORT : S_LAUNCH;
            S_REPORT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        busy       = (state_q != S_IDLE);
        done       = (state_q == S_REPORT);
        xact_start = (state_q == S_LAUNCH);
        xact_write = txn.write;
        xact_ext   = txn.ext;
        xact_reg   = txn.reg_sel;
        xact_addr  = txn.ram_addr;
        xact_wdata = txn.wdata;
    end

    // Operation context and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_GET_TIME;
            time_q   <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            step_q   <= '0;
            passes_q <= '0;
            result   <= '0;
            error    <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        op_q     <= op_e'(req_op);
                        time_q   <= req_time;
                        addr_q   <= req_addr;
                        data_q   <= req_wdata;
                        step_q   <= '0;
                        passes_q <= '0;
                    end
                end
                S_AWAIT: begin
                    if (xact_done) begin
                        if (!step_last) step_q <= step_q + STEP_W'(1);
                        if (op_q == OP_RAM_READ) begin
                            result <= TIME_W'(xact_rdata);
                            error  <= 1'b0;
                        end else if (step_last && op_q != OP_GET_TIME) begin
                            result <= '0;
                            error  <= 1'b0;
                        end
                    end
                end
                S_JUDGE: begin
                    if (judge_ok) begin
                        result <= unix_get;
                        error  <= 1'b0;
                    end else if (judge_fail) begin
                        result <= '0;
                        error  <= 1'b1;
                    end else begin
                        passes_q <= passes_q + PASS_W'(1);
                        step_q   <= '0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rtc_op_sequencer_chk.sv
module rtc_op_sequencer_chk #(
    parameter int TIME_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic [TIME_W-1:0] result,
    input logic              error,
    input logic              xact_start,
    input logic              xact_done
);
    logic outstanding;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          outstanding <= 1'b0;
        else if (xact_start) outstanding <= 1'b1;
        else if (xact_done)  outstanding <= 1'b0;
    end

    // R9: a start is a single-cycle pulse
    a_r9_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xact_start |=> !xact_start);

    // R9: no new start while a transaction is unanswered
    a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        xact_start |-> !outstanding);

    // R9: transactions only inside an operation
    a_r9_start_in_op: assert property (@(posedge clk) disable iff (!rst_n)
        xact_start |-> busy);

    // R8: done lasts one cycle and ends the operation
    a_r8_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R8: results hold while idle
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(result) && $stable(error)));

    // R7: an operation begins only from a request
    a_r7_begin_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R3: a failed time read reports zero
    a_r3_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && error) |-> (result == '0));
endmodule

bind rtc_op_sequencer rtc_op_sequencer_chk #(.TIME_W(TIME_W)) i_chk (.*);

// File: tb/test_rtc_op_sequencer.sv
module test_rtc_op_sequencer;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] GAP = 32'd2082844800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [31:0] req_time = '0;
    logic [7:0]  req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done, error;
    logic [31:0] result;
    logic        xact_start, xact_write, xact_ext;
    logic [3:0]  xact_reg;
    logic [7:0]  xact_addr, xact_wdata;
    logic        xact_done = 1'b0;
    logic [7:0]  xact_rdata = '0;

    rtc_op_sequencer i_rtc_op_sequencer (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Chip model
    logic [31:0] s_time = 32'h0;
    logic        s_wp = 1'b1;
    logic [7:0]  s_ram [256];
    int          s_bump = 0;
    int          pend = 0;
    int          lat_cnt = 0;
    logic [7:0]  pend_rdata = '0;
    int          txn_idx = 0;

    // Reference model
    logic [21:0] exp_q [$];
    logic        exp_busy = 1'b0;
    string       cur_tag = "R1";
    logic        done_seen = 1'b0;
    logic [31:0] last_result = '0;
    logic        last_error = 1'b0;
    int          cycles = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [21:0] mk(input logic w, input logic e, input logic [3:0] r,
                                       input logic [7:0] a, input logic [7:0] d);
        return {w, e, r, a, d};
    endfunction

    task automatic build_queue(input logic [1:0] op, input logic [31:0] t,
                               input logic [7:0] a, input logic [7:0] d);
        logic [31:0] chip;
        int passes;
        exp_q.delete();
        case (op)
            2'd0: begin
                cur_tag = "R1";
                passes = (s_bump >= 10) ? 11 : s_bump + 2;
                for (int p = 0; p < passes; p++)
                    for (int r = 0; r < 4; r++) exp_q.push_back(mk(1'b0, 1'b0, 4'(r), 8'h0, 8'h0));
            end
            2'd1: begin
                cur_tag = "R4";
                chip = t + GAP;
                exp_q.push_back(mk(1'b1, 1'b0, 4'd13, 8'h0, 8'h55));
                for (int r = 0; r < 4; r++) exp_q.push_back(mk(1'b1, 1'b0, 4'(r), 8'h0, chip[r*8 +: 8]));
                exp_q.push_back(mk(1'b1, 1'b0, 4'd13, 8'h0, 8'hD5));
            end
            2'd2: begin
                cur_tag = "R6";
                exp_q.push_back(mk(1'b0, 1'b1, 4'd14, a, 8'h0));
            end
            default: begin
                cur_tag = "R5";
                exp_q.push_back(mk(1'b1, 1'b0, 4'd13, 8'h0, 8'h55));
                exp_q.push_back(mk(1'b1, 1'b1, 4'd14, a, d));
                exp_q.push_back(mk(1'b1, 1'b0, 4'd13, 8'h0, 8'hD5));
            end
        endcase
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
            chk(busy == exp_busy, "R8", "busy", 32'(busy), 32'(exp_busy));
            if (done) begin
                chk(exp_q.size() == 0, "R9", "transactions left at done", exp_q.size(), 0);
                last_result = result;
                last_error  = error;
                done_seen   = 1'b1;
            end
            xact_done = 1'b0;
            if (pend != 0) begin
                lat_cnt--;
                if (lat_cnt == 0) begin
                    xact_done  = 1'b1;
                    xact_rdata = pend_rdata;
                    pend = 0;
                end
            end
            if (xact_start) begin
                logic [21:0] e;
                chk(pend == 0, "R9", "start while outstanding", 32'(pend), 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected transaction",
                        {10'h0, xact_write, xact_ext, xact_reg, xact_addr, xact_wdata}, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(xact_write == e[21] && xact_ext == e[20] && xact_reg == e[19:16]
                        && (!e[20] || xact_addr == e[15:8]) && (!e[21] || xact_wdata == e[7:0]),
                        cur_tag, "R10 transaction fields",
                        {10'h0, xact_write, xact_ext, xact_reg, xact_addr, xact_wdata}, {10'h0, e});
                end
                if (xact_write) begin
                    if (xact_reg == 4'd13) s_wp = xact_wdata[7];
                    else if (!s_wp) begin
                        if (xact_ext) s_ram[xact_addr] = xact_wdata;
                        else if (xact_reg < 4) s_time[int'(xact_reg)*8 +: 8] = xact_wdata;
                    end
                    pend_rdata = 8'h0;
                end else begin
                    if (xact_ext) pend_rdata = s_ram[xact_addr];
                    else pend_rdata = s_time[int'(xact_reg[1:0])*8 +: 8];
                    if (!xact_ext && xact_reg == 4'd3 && s_bump > 0) begin
                        s_time++;
                        s_bump--;
                    end
                end
                pend = 1;
                lat_cnt = 1 + (txn_idx % 3);
                txn_idx++;
            end
            if (done) exp_busy = 1'b0;
            else if (req_valid && !exp_busy) begin
                exp_busy = 1'b1;
                build_queue(req_op, req_time, req_addr, req_wdata);
            end
        end
    end

    task automatic start_req(input logic [1:0] op, input logic [31:0] t,
                             input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        req_op = op; req_time = t; req_addr = a; req_wdata = d; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input logic [31:0] exp_res, input logic exp_err, input string tag);
        wait (done_seen);
        @(posedge clk); #1;
        chk(last_result == exp_res, tag, "result", last_result, exp_res);
        chk(last_error == exp_err, tag, "error", 32'(last_error), 32'(exp_err));
    endtask

    task automatic run_op(input logic [1:0] op, input logic [31:0] t, input logic [7:0] a,
                          input logic [7:0] d, input logic [31:0] exp_res,
                          input logic exp_err, input string tag);
        done_seen = 1'b0;
        start_req(op, t, a, d);
        wait_done(exp_res, exp_err, tag);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) s_ram[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !xact_start, "R8", "reset idle", {busy, done, xact_start}, 0);
        chk(result == 0 && !error, "R3", "reset result", result, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R1 R2: stable on second pass
        s_time = 32'h8A3C_5E71; s_bump = 0;
        run_op(2'd0, 0, 0, 0, 32'h8A3C_5E71 - GAP, 1'b0, "R2");
        // R2: value below the gap wraps
        s_time = 32'h0000_0010; s_bump = 0;
        run_op(2'd0, 0, 0, 0, 32'h0000_0010 - GAP, 1'b0, "R2");
        // R2: settles after three ticks
        s_time = 32'h9000_00FE; s_bump = 3;
        run_op(2'd0, 0, 0, 0, 32'h9000_0101 - GAP, 1'b0, "R2");
        // R3: nine ticks settles on the eleventh pass
        s_time = 32'hA1B2_C3F9; s_bump = 9;
        run_op(2'd0, 0, 0, 0, 32'hA1B2_C402 - GAP, 1'b0, "R3");
        // R3: ten ticks exhausts the budget
        s_time = 32'h7000_0000; s_bump = 10;
        run_op(2'd0, 0, 0, 0, 32'h0, 1'b1, "R3");
        // R8: held after completion
        repeat (5) @(posedge clk);
        #1 chk(result == 0 && error == 1'b1, "R8", "hold after done", {result[30:0], error}, 1);

        // R4: set then read back; guard closed afterwards
        run_op(2'd1, 32'h6000_0001, 0, 0, 32'h0, 1'b0, "R4");
        chk(s_time == 32'h6000_0001 + GAP, "R4", "chip time", s_time, 32'h6000_0001 + GAP);
        chk(s_wp == 1'b1, "R4", "guard closed", 32'(s_wp), 1);
        s_bump = 0;
        run_op(2'd0, 0, 0, 0, 32'h6000_0001, 1'b0, "R4");
        // R4: offset addition wraps
        run_op(2'd1, 32'hFFFF_FFF0, 0, 0, 32'h0, 1'b0, "R4");
        chk(s_time == 32'h7C25_B070, "R4", "wrapped chip time", s_time, 32'h7C25_B070);
        run_op(2'd0, 0, 0, 0, 32'hFFFF_FFF0, 1'b0, "R4");

        // R5 R6: RAM write and reads
        run_op(2'd3, 0, 8'hA7, 8'h3C, 32'h0, 1'b0, "R5");
        chk(s_wp == 1'b1, "R5", "guard closed", 32'(s_wp), 1);
        run_op(2'd2, 0, 8'hA7, 0, 32'h0000_003C, 1'b0, "R6");
        run_op(2'd2, 0, 8'hFF, 0, 32'h0000_00A5, 1'b0, "R6");
        run_op(2'd3, 0, 8'h00, 8'hC1, 32'h0, 1'b0, "R5");
        run_op(2'd2, 0, 8'h00, 0, 32'h0000_00C1, 1'b0, "R6");

        // R7: request during a long time read is ignored
        s_time = 32'h1234_5678; s_bump = 2;
        done_seen = 1'b0;
        start_req(2'd0, 0, 0, 0);
        repeat (6) @(posedge clk);
        start_req(2'd3, 0, 8'h05, 8'hEE);
        wait_done(32'h1234_567A - GAP, 1'b0, "R7");
        run_op(2'd2, 0, 8'h05, 0, 32'h0000_005F, 1'b0, "R7");

        repeat (4) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule